// File: doc/BRIEF.md
# Doorbell Command Mailbox

This block is a small memory-mapped register window through which a host hands a command to a device and collects the result. The host writes a command word (command group, opcode and input length) and, if the command needs input, fills a payload window. It then sets a doorbell bit. An internal sequencer looks the group and opcode up in a short table of built-in commands and checks the given input length against the length that entry expects. It runs the matching handler, rewrites the command word with the output length, posts a return code in the status register and drops the doorbell. The host polls the doorbell to learn that the command has finished.

Host accesses are either 4 or 8 bytes wide. An access is honoured only when its byte offset is a multiple of its own width. Each register accepts writes only at its natural width, and the status registers belong to the sequencer alone.

The memory map is: 0x00 capability (32-bit), 0x04 control (32-bit), 0x08 command (64-bit), 0x10 status (64-bit), 0x18 background status (64-bit) and 0x20 onward the payload window of 2^PAY_EXP bytes. A 32-bit access reads or writes the low or high half of the 8-byte slot, as chosen by address bit 2, and the data sits in bits 31:0 of the bus.

Top module: `mbox_top`

## Requirements
- R1: After reset the capability register reads the payload size exponent in bits 4:0 (11, meaning 2048 bytes), with interrupt support (bit 5) and background support (bit 6) both zero. Control, command, status and payload word 0 all read zero.
- R2: A 4-byte access whose offset is not a multiple of 4, or an 8-byte access whose offset is not a multiple of 8, has no effect and reads zero.
- R3: The control register (doorbell in bit 0) takes only 4-byte writes, and the command register takes only 8-byte writes. Writes to the capability, status (0x10) and background status (0x18) registers are ignored. The payload window takes writes of both widths.
- R4: The command register holds the opcode in bits 7:0, the command group in bits 15:8 and the input length in bits 35:16. Bits 63:36 read as zero.
- R5: After the host write that sets the doorbell, the doorbell reads one during the next three cycles and reads zero from the fourth cycle on.
- R6: On completion the group and opcode fields read zero and the length field holds the output length. The status register holds the return code in bits 47:32, with every other bit zero.
- R7: A group/opcode pair that is not in the table completes with return code 0x03 and output length 0.
- R8: A listed command whose input length differs from its table length completes with code 0x16 and output length 0, and leaves the payload untouched.
- R9: The built-in commands are as follows. Group 0x00 opcode 0x01 (input 0) returns code 0x00 with output length 0. Group 0x00 opcode 0x02 (input 8) replaces payload word 0 with its bitwise inverse and returns code 0x00 with output length 8; if that word is zero it instead returns 0x02 with output length 0. Group 0x01 opcode 0x00 (input 0) writes {table entry count, payload bytes} (0x00000003_00000800) to payload word 0 and returns code 0x00 with output length 8.
- R10: While the doorbell is set, host writes to the command register, the payload window and the control register are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Host access valid this cycle |
| host_we | input | 1 | 1 for write, 0 for read |
| host_wide | input | 1 | 1 for an 8-byte access, 0 for a 4-byte access |
| host_addr | input | ADDR_W (12) | Byte offset into the register window |
| host_wdata | input | 64 | Write data (4-byte accesses use bits 31:0) |
| host_rdata | output | 64 | Read data, valid in the cycle of a read request |

## Verification
The bench targets the width and alignment corners: a 4-byte write landing on the command register, an 8-byte write at offset 0 that would otherwise set the doorbell, and 4-aligned but 8-misaligned payload writes. A design that decoded by address alone would corrupt the command or start a command on its own. The doorbell is sampled on each of the cycles after it is rung, so an off-by-one in the sequencer shows up as an early or late clear. Length mismatch, an unlisted opcode and a zero input to the invert command each have a distinct return code, and the bench also checks that the payload was not changed. A design that ran the handler before the length check, or reported success by default, would fail here. Writes issued during the busy window are checked afterwards: a leaky lockout would change the result code or the payload.

// File: rtl/mbox_pkg.sv
// Shared types for the doorbell command mailbox: field widths, return codes,
// command table descriptors and the sequencer state encoding.
package mbox_pkg;

    localparam int DATA_W   = 64;
    localparam int OPC_W    = 8;
    localparam int GRP_W    = 8;
    localparam int LEN_W    = 20;
    localparam int CMD_W    = OPC_W + GRP_W + LEN_W;
    localparam int RC_W     = 16;
    localparam int PAY_BASE = 32;
    localparam int NUM_CMDS = 3;

    typedef enum logic [RC_W-1:0] {
        RC_OK          = 16'h0000,
        RC_BG_STARTED  = 16'h0001,
        RC_BAD_INPUT   = 16'h0002,
        RC_UNSUPPORTED = 16'h0003,
        RC_BUSY        = 16'h0006,
        RC_BAD_LENGTH  = 16'h0016
    } rc_e;

    typedef enum logic [1:0] {
        H_NOP,
        H_INVERT,
        H_INFO
    } handler_e;

    typedef struct packed {
        logic [GRP_W-1:0] grp;
        logic [OPC_W-1:0] opc;
        logic [LEN_W-1:0] in_len;
        handler_e         kind;
    } cmd_desc_t;

    typedef struct packed {
        rc_e              rc;
        logic [LEN_W-1:0] out_len;
        logic             wr_en;
        logic [DATA_W-1:0] wr_word;
    } cmd_result_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LOOKUP,
        SQ_EXEC
    } seq_state_e;

    // Built-in command table, one descriptor per index.
    function automatic cmd_desc_t cmd_desc(input int idx);
        cmd_desc_t d;
        case (idx)
            0:       d = '{grp: 8'h00, opc: 8'h01, in_len: 20'd0, kind: H_NOP};
            1:       d = '{grp: 8'h00, opc: 8'h02, in_len: 20'd8, kind: H_INVERT};
            2:       d = '{grp: 8'h01, opc: 8'h00, in_len: 20'd0, kind: H_INFO};
            default: d = '{grp: 8'hFF, opc: 8'hFF, in_len: 20'd0, kind: H_NOP};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/mbox_cmd_table.sv
// Command lookup and built-in handlers.
// Purely combinational: matches group/opcode against the table, checks the
// input length, and computes return code, output length and payload update.
// Assumes the command fields and payload word 0 are stable while consumed.
module mbox_cmd_table
    import mbox_pkg::*;
#(
    parameter int PAY_EXP = 11
) (
    input  logic [GRP_W-1:0]  grp_i,
    input  logic [OPC_W-1:0]  opc_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [DATA_W-1:0] word0_i,
    output cmd_result_t       res_o
);

    localparam int PAY_BYTES = 1 << PAY_EXP;

    // Result of one table entry, assuming it matched.
    function automatic cmd_result_t run_entry(input cmd_desc_t d,
                                              input logic [LEN_W-1:0] len,
                                              input logic [DATA_W-1:0] w);
        cmd_result_t r;
        r.rc      = RC_OK;
        r.out_len = '0;
        r.wr_en   = 1'b0;
        r.wr_word = '0;
        if (len != d.in_len) begin
            r.rc = RC_BAD_LENGTH;
        end else begin
            case (d.kind)
                H_INVERT: begin
                    if (w == '0) begin
                        r.rc = RC_BAD_INPUT;
                    end else begin
                        r.out_len = LEN_W'(8);
                        r.wr_en   = 1'b1;
                        r.wr_word = ~w;
                    end
                end
                H_INFO: begin
                    r.out_len = LEN_W'(8);
                    r.wr_en   = 1'b1;
                    r.wr_word = {32'(NUM_CMDS), 32'(PAY_BYTES)};
                end
                default: ;
            endcase
        end
        return r;
    endfunction

    logic [NUM_CMDS-1:0] hit;
    cmd_result_t         ent_res [NUM_CMDS];

    generate
        for (genvar g = 0; g < NUM_CMDS; g++) begin : g_ent
            localparam cmd_desc_t D = cmd_desc(g);
            assign hit[g]     = (grp_i == D.grp) && (opc_i == D.opc);
            assign ent_res[g] = run_entry(D, len_i, word0_i);
        end
    endgenerate

    // First matching entry wins; no match reports an unsupported command.
    always_comb begin
        res_o = '{rc: RC_UNSUPPORTED, out_len: '0, wr_en: 1'b0, wr_word: '0};
        for (int i = NUM_CMDS - 1; i >= 0; i--) begin
            if (hit[i]) res_o = ent_res[i];
        end
    end

endmodule

// File: rtl/mbox_seq.sv
// Command sequencer.
// Sees the doorbell, registers the table result one cycle later, and issues
// a one-cycle completion strobe the cycle after that. Fixed latency: the
// doorbell clears on the third clock edge after it is set.
// Assumes the doorbell stays set until the completion strobe.
module mbox_seq
    import mbox_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        doorbell_i,
    input  cmd_result_t res_i,
    output logic        done_o,
    output cmd_result_t res_o
);

    seq_state_e  state_q;
    cmd_result_t res_q;

    // State walk: idle -> lookup -> exec -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
        end else begin
            case (state_q)
                SQ_IDLE:   if (doorbell_i) state_q <= SQ_LOOKUP;
                SQ_LOOKUP: state_q <= SQ_EXEC;
                default:   state_q <= SQ_IDLE;
            endcase
        end
    end

    // Capture the decoded result at the end of the lookup cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '{rc: RC_OK, out_len: '0, wr_en: 1'b0, wr_word: '0};
        end else if (state_q == SQ_LOOKUP) begin
            res_q <= res_i;
        end
    end

    assign done_o = (state_q == SQ_EXEC);
    assign res_o  = res_q;

    AST_BUSY_HOLDS_DB: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SQ_IDLE) |-> doorbell_i);                              // R5
    AST_RING_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(doorbell_i) |=> (state_q == SQ_LOOKUP));                     // R5

endmodule

// File: rtl/mbox_regs.sv
// Host register file and access decoder.
// Applies the width and alignment rules, holds the control, command and status
// registers and the payload window, and folds in the sequencer's completion.
// Assumes done_i is only raised while the doorbell is set.
module mbox_regs
    import mbox_pkg::*;
#(
    parameter int PAY_EXP = 11,
    parameter int ADDR_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req_i,
    input  logic              host_we_i,
    input  logic              host_wide_i,
    input  logic [ADDR_W-1:0] host_addr_i,
    input  logic [DATA_W-1:0] host_wdata_i,
    output logic [DATA_W-1:0] host_rdata_o,
    input  logic              done_i,
    input  cmd_result_t       res_i,
    output logic              doorbell_o,
    output logic [GRP_W-1:0]  grp_o,
    output logic [OPC_W-1:0]  opc_o,
    output logic [LEN_W-1:0]  len_o,
    output logic [DATA_W-1:0] word0_o
);

    localparam int PAY_BYTES = 1 << PAY_EXP;
    localparam int PAY_WORDS = PAY_BYTES / 8;
    localparam int IDX_W     = PAY_EXP - 3;
    localparam int SLOT_W    = ADDR_W - 3;
    localparam logic [SLOT_W-1:0] SLOT_CAPCTRL = SLOT_W'(0);
    localparam logic [SLOT_W-1:0] SLOT_CMD     = SLOT_W'(1);
    localparam logic [SLOT_W-1:0] SLOT_STS     = SLOT_W'(2);

    logic              aligned;
    logic              accept;
    logic              in_pay;
    logic [SLOT_W-1:0] slot;
    logic [IDX_W-1:0]  pay_idx;
    logic [DATA_W-1:0] slot_val;
    logic [31:0]       cap_word;
    logic [31:0]       ctrl_word;

    logic              db_q;
    logic [CMD_W-1:0]  cmd_q;
    rc_e               rc_q;
    logic [DATA_W-1:0] pay_mem [PAY_WORDS];

    assign aligned  = host_wide_i ? (host_addr_i[2:0] == 3'b000)
                                  : (host_addr_i[1:0] == 2'b00);
    assign accept   = host_req_i && host_we_i && aligned && !db_q;
    assign slot     = host_addr_i[ADDR_W-1:3];
    assign in_pay   = (int'(host_addr_i) >= PAY_BASE) &&
                      (int'(host_addr_i) < PAY_BASE + PAY_BYTES);
    assign pay_idx  = IDX_W'((host_addr_i - ADDR_W'(PAY_BASE)) >> 3);
    assign cap_word = {25'h0, 1'b0, 1'b0, 5'(PAY_EXP)};
    assign ctrl_word = {31'h0, db_q};

    // Doorbell: host may set it only while idle; completion clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            db_q <= 1'b0;
        end else if (done_i) begin
            db_q <= 1'b0;
        end else if (accept && !host_wide_i && slot == SLOT_CAPCTRL && host_addr_i[2]) begin
            db_q <= host_wdata_i[0];
        end
    end

    // Command register: 8-byte host writes, rewritten with output length on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (done_i) begin
            cmd_q <= {res_i.out_len, 16'h0000};
        end else if (accept && host_wide_i && slot == SLOT_CMD && !in_pay) begin
            cmd_q <= host_wdata_i[CMD_W-1:0];
        end
    end

    // Status return code: written only by the sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rc_q <= RC_OK;
        end else if (done_i) begin
            rc_q <= res_i.rc;
        end
    end

    // Payload window: host writes of either width, handler result into word 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PAY_WORDS; i++) pay_mem[i] <= '0;
        end else if (done_i && res_i.wr_en) begin
            pay_mem[0] <= res_i.wr_word;
        end else if (accept && in_pay) begin
            if (host_wide_i)           pay_mem[pay_idx]        <= host_wdata_i;
            else if (host_addr_i[2])   pay_mem[pay_idx][63:32] <= host_wdata_i[31:0];
            else                       pay_mem[pay_idx][31:0]  <= host_wdata_i[31:0];
        end
    end

    // Read mux: select the 8-byte slot, then the half for 4-byte reads.
    always_comb begin
        slot_val = '0;
        if (in_pay) begin
            slot_val = pay_mem[pay_idx];
        end else begin
            case (slot)
                SLOT_CAPCTRL: slot_val = {ctrl_word, cap_word};
                SLOT_CMD:     slot_val = {{(DATA_W-CMD_W){1'b0}}, cmd_q};
                SLOT_STS:     slot_val = {16'h0000, rc_q, 32'h0};
                default:      slot_val = '0;
            endcase
        end
        host_rdata_o = '0;
        if (host_req_i && !host_we_i && aligned) begin
            host_rdata_o = host_wide_i ? slot_val
                         : {32'h0, (host_addr_i[2] ? slot_val[63:32] : slot_val[31:0])};
        end
    end

    assign doorbell_o = db_q;
    assign opc_o      = cmd_q[7:0];
    assign grp_o      = cmd_q[15:8];
    assign len_o      = cmd_q[35:16];
    assign word0_o    = pay_mem[0];

    AST_DONE_NEEDS_DB: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |-> db_q);                                                  // R5
    AST_DB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> !db_q);                                                 // R6
    AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (db_q && !done_i) |=> $stable(cmd_q));                             // R10
    AST_PAY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (db_q && !done_i) |=> $stable(pay_mem[0]));                        // R10

endmodule

// File: rtl/mbox_top.sv
// Doorbell command mailbox top level.
// Connects the host register file, the command table and the sequencer.
// Assumes a single host issuing one access per cycle at most.
module mbox_top
    import mbox_pkg::*;
#(
    parameter  int PAY_EXP = 11,
    localparam int ADDR_W  = $clog2(PAY_BASE + (1 << PAY_EXP))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic              host_wide,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [63:0]       host_wdata,
    output logic [63:0]       host_rdata
);

    logic              doorbell;
    logic              done;
    logic [GRP_W-1:0]  grp;
    logic [OPC_W-1:0]  opc;
    logic [LEN_W-1:0]  len;
    logic [DATA_W-1:0] word0;
    cmd_result_t       lookup_res;
    cmd_result_t       done_res;

    mbox_regs #(.PAY_EXP(PAY_EXP), .ADDR_W(ADDR_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_req_i   (host_req),
        .host_we_i    (host_we),
        .host_wide_i  (host_wide),
        .host_addr_i  (host_addr),
        .host_wdata_i (host_wdata),
        .host_rdata_o (host_rdata),
        .done_i       (done),
        .res_i        (done_res),
        .doorbell_o   (doorbell),
        .grp_o        (grp),
        .opc_o        (opc),
        .len_o        (len),
        .word0_o      (word0)
    );

    mbox_cmd_table #(.PAY_EXP(PAY_EXP)) u_table (
        .grp_i   (grp),
        .opc_i   (opc),
        .len_i   (len),
        .word0_i (word0),
        .res_o   (lookup_res)
    );

    mbox_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .doorbell_i (doorbell),
        .res_i      (lookup_res),
        .done_o     (done),
        .res_o      (done_res)
    );

endmodule

// File: tb/mbox_top_tb.sv
// Scoreboard bench: driver tasks queue expected read data, a monitor at the
// falling edge pops and compares whenever a read is on the bus.
module mbox_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic        host_wide = 1'b0;
    logic [11:0] host_addr = '0;
    logic [63:0] host_wdata = '0;
    logic [63:0] host_rdata;

    int checks = 0;
    int errors = 0;
    logic [63:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    mbox_top u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_wide  (host_wide),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    // Monitor: compare each observed read against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && host_req && !host_we) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL unexpected read actual=%h expected=none", host_rdata);
            end else begin
                logic [63:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (host_rdata !== e) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", t, host_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic wide, input logic [63:0] d);
        @(posedge clk); #1;
        host_req = 1'b1; host_we = 1'b1; host_wide = wide; host_addr = a; host_wdata = d;
        @(posedge clk); #1;
        host_req = 1'b0; host_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic wide, input logic [63:0] e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        @(posedge clk); #1;
        host_req = 1'b1; host_we = 1'b0; host_wide = wide; host_addr = a;
        @(posedge clk); #1;
        host_req = 1'b0;
    endtask

    // Ring the doorbell, then read it on each of the following four cycles.
    task automatic ring_watch(input string t);
        @(posedge clk); #1;
        host_req = 1'b1; host_we = 1'b1; host_wide = 1'b0; host_addr = 12'h004; host_wdata = 64'h1;
        for (int k = 0; k < 4; k++) begin
            exp_q.push_back((k < 3) ? 64'h1 : 64'h0);
            tag_q.push_back(t);
            @(posedge clk); #1;
            host_req = 1'b1; host_we = 1'b0; host_wide = 1'b0; host_addr = 12'h004;
        end
        @(posedge clk); #1;
        host_req = 1'b0;
    endtask

    task automatic run_cmd(input logic [7:0] g, input logic [7:0] o, input logic [19:0] l, input string t);
        wr(12'h008, 1'b1, {28'h0, l, g, o});
        ring_watch(t);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog (all requirements) actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(12'h000, 1'b0, 64'h0000_000B, "R1 capability");
        rd(12'h004, 1'b0, 64'h0, "R1 control");
        rd(12'h008, 1'b1, 64'h0, "R1 command");
        rd(12'h010, 1'b1, 64'h0, "R1 status");
        rd(12'h020, 1'b1, 64'h0, "R1 payload");

        // R4 command field layout and reserved bits
        wr(12'h008, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(12'h008, 1'b1, 64'h0000_000F_FFFF_FFFF, "R4 command reserved bits");
        rd(12'h008, 1'b0, 64'hFFFF_FFFF, "R4 command low half");
        rd(12'h00C, 1'b0, 64'h0000_000F, "R4 command high half");

        // R3 width rules and read-only registers
        wr(12'h008, 1'b0, 64'h1234_5678);
        rd(12'h008, 1'b1, 64'h0000_000F_FFFF_FFFF, "R3 narrow command write ignored");
        wr(12'h010, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(12'h010, 1'b1, 64'h0, "R3 status write ignored");
        wr(12'h018, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(12'h018, 1'b1, 64'h0, "R3 background status write ignored");
        wr(12'h000, 1'b0, 64'hFFFF_FFFF);
        rd(12'h000, 1'b0, 64'h0000_000B, "R3 capability write ignored");
        wr(12'h000, 1'b1, 64'h0000_0001_0000_0000);
        rd(12'h004, 1'b0, 64'h0, "R3 wide control write ignored");

        // R2 alignment
        rd(12'h00C, 1'b1, 64'h0, "R2 unaligned wide read");
        rd(12'h006, 1'b0, 64'h0, "R2 unaligned narrow read");
        wr(12'h005, 1'b0, 64'h1);
        rd(12'h004, 1'b0, 64'h0, "R2 unaligned control write");
        wr(12'h024, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(12'h020, 1'b1, 64'h0, "R2 unaligned wide payload write");
        wr(12'h024, 1'b0, 64'hAABB_CCDD);
        wr(12'h020, 1'b0, 64'h1122_3344);
        rd(12'h020, 1'b1, 64'hAABB_CCDD_1122_3344, "R3 narrow payload writes");

        // R5 R9 no-op command
        run_cmd(8'h00, 8'h01, 20'd0, "R5 doorbell latency no-op");
        rd(12'h008, 1'b1, 64'h0, "R6 command after no-op");
        rd(12'h010, 1'b1, 64'h0, "R9 no-op status");

        // R7 unsupported command
        run_cmd(8'h07, 8'h33, 20'h10, "R5 doorbell latency unsupported");
        rd(12'h008, 1'b1, 64'h0, "R7 unsupported output length");
        rd(12'h010, 1'b1, 64'h0000_0003_0000_0000, "R7 unsupported code");

        // R8 length mismatch
        wr(12'h020, 1'b1, 64'h0123_4567_89AB_CDEF);
        run_cmd(8'h00, 8'h02, 20'd4, "R5 doorbell latency bad length");
        rd(12'h010, 1'b1, 64'h0000_0016_0000_0000, "R8 bad length code");
        rd(12'h008, 1'b1, 64'h0, "R8 bad length output length");
        rd(12'h020, 1'b1, 64'h0123_4567_89AB_CDEF, "R8 payload untouched");

        // R9 invert command
        run_cmd(8'h00, 8'h02, 20'd8, "R5 doorbell latency invert");
        rd(12'h010, 1'b1, 64'h0, "R9 invert status");
        rd(12'h008, 1'b1, 64'h0000_0000_0008_0000, "R6 invert output length");
        rd(12'h020, 1'b1, 64'hFEDC_BA98_7654_3210, "R9 invert payload");

        // R9 invert of zero is invalid input
        wr(12'h020, 1'b1, 64'h0);
        run_cmd(8'h00, 8'h02, 20'd8, "R5 doorbell latency invert zero");
        rd(12'h010, 1'b1, 64'h0000_0002_0000_0000, "R9 invert zero code");
        rd(12'h008, 1'b1, 64'h0, "R9 invert zero output length");
        rd(12'h020, 1'b1, 64'h0, "R9 invert zero payload");

        // R9 info command
        run_cmd(8'h01, 8'h00, 20'd0, "R5 doorbell latency info");
        rd(12'h020, 1'b1, 64'h0000_0003_0000_0800, "R9 info payload");
        rd(12'h008, 1'b1, 64'h0000_0000_0008_0000, "R9 info output length");
        rd(12'h010, 1'b1, 64'h0, "R9 info status");

        // R10 writes dropped while busy
        wr(12'h020, 1'b1, 64'h0);
        run_cmd(8'h00, 8'h02, 20'd8, "R5 doorbell latency setup");
        rd(12'h010, 1'b1, 64'h0000_0002_0000_0000, "R10 setup code");
        wr(12'h008, 1'b1, {28'h0, 20'd0, 8'h00, 8'h01});
        @(posedge clk); #1;
        host_req = 1'b1; host_we = 1'b1; host_wide = 1'b0; host_addr = 12'h004; host_wdata = 64'h1;
        @(posedge clk); #1;
        host_wide = 1'b1; host_addr = 12'h008; host_wdata = {28'h0, 20'h10, 8'h07, 8'h33};
        @(posedge clk); #1;
        host_wide = 1'b1; host_addr = 12'h028; host_wdata = 64'hDEAD_BEEF_CAFE_F00D;
        @(posedge clk); #1;
        host_wide = 1'b0; host_addr = 12'h004; host_wdata = 64'h0;
        @(posedge clk); #1;
        host_req = 1'b0; host_we = 1'b0;
        repeat (2) @(posedge clk);
        rd(12'h010, 1'b1, 64'h0, "R10 command held during busy");
        rd(12'h008, 1'b1, 64'h0, "R10 command result");
        rd(12'h028, 1'b1, 64'h0, "R10 payload write dropped");
        rd(12'h004, 1'b0, 64'h0, "R10 doorbell clear");

        repeat (3) @(posedge clk);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard drain actual=%0d expected=0", exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule